// File: doc/BRIEF.md
# Byte-Lane Read Parity Checker

This block guards a 64-bit read data path that is split into eight byte lanes. Each lane carries its own even-parity bit and its own byte enable. On every clock where the read-data-valid strobe is high, the block checks each enabled lane. On the following clock it reports the outcome on an active-low check output and on a per-lane error vector. A separate parity-enable input decides whether a detected mismatch is flagged at all.

The same block also holds a combinational parity generator for the write direction. The source of a write can take correct lane parity bits from it and drive them next to its data.

Top module: `byte_lane_parity_chk`

## Requirements
- R1: After reset, and until the first read is checked, `chk_n` is 1 and `lane_err` is all zeros.
- R2: Lane n is the byte `rd_data[8n+7:8n]`, so lane 0 is the least significant byte. Lane n is covered only by `rd_par[n]`. Parity is even: lane n mismatches when its eight data bits plus `rd_par[n]` hold an odd number of ones.
- R3: A lane whose enable bit `rd_be[n]` is 0 is never flagged, whatever its data and parity bit hold.
- R4: Every pattern of the eight byte enables is accepted, including patterns with gaps such as 8'hA5. Each enabled lane is judged on its own.
- R5: A result is reported only for a clock on which `rd_valid` is 1. The clock after a cycle with `rd_valid` at 0 shows `chk_n` = 1 and `lane_err` = 0, even when the data has bad parity.
- R6: When `par_chk_en` is 0 during a strobe, nothing is flagged on the next clock.
- R7: `chk_n` goes low on exactly the clock after a strobe with `par_chk_en` at 1 and at least one enabled mismatching lane. It stays low for one clock per such strobe, so back-to-back failing strobes hold it low on consecutive clocks.
- R8: `lane_err` is registered on the same edge as `chk_n`. Bit n is 1 exactly when lane n was enabled and mismatched in a flagged check. It is all zeros whenever `chk_n` is 1.
- R9: `wr_par[n]` gives lane n of `wr_data` even parity. It is combinational, and it does not depend on the byte enables or on any read-side input.
- R10: When `rd_be` is all zeros during a strobe, no error is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs except `wr_par` change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_data | input | 64 | Read data, eight byte lanes |
| rd_par | input | 8 | Even-parity bit per read lane |
| rd_be | input | 8 | Byte enable per read lane; 1 = lane is checked |
| par_chk_en | input | 1 | 1 = detected mismatches are flagged |
| rd_valid | input | 1 | Read-data-valid strobe |
| wr_data | input | 64 | Write data to receive parity |
| wr_par | output | 8 | Generated even-parity bit per write lane |
| chk_n | output | 1 | Active-low parity check result, one clock after the strobe |
| lane_err | output | 8 | Per-lane error flags, registered with `chk_n` |

## Verification
The assertions assume that every input is a known value at each rising clock edge once reset is released. This includes `wr_data`, whose lane parity is checked on every clock. They place no limit on how strobes, enables or the parity-enable input are sequenced. The stimulus therefore changes all inputs only on falling edges and gives `wr_data` a defined value from time zero. It mixes idle cycles, back-to-back strobes, gapped enable patterns and deliberately corrupted lanes, so that every property's antecedent is exercised.

// File: rtl/blpar_pkg.sv
package blpar_pkg;

  // Width of one byte lane; the lane layout is fixed by the bus.
  localparam int unsigned LANE_W = 8;

  // Bit that brings a lane to an even count of ones.
  function automatic logic even_fill(input logic [LANE_W-1:0] lane);
    return ^lane;
  endfunction

  // 1 when a lane and its parity bit together hold an odd count of ones.
  function automatic logic lane_bad(input logic [LANE_W-1:0] lane, input logic pbit);
    return even_fill(lane) ^ pbit;
  endfunction

endpackage

// File: rtl/lane_par_gen.sv
module lane_par_gen
  import blpar_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic [LANES*LANE_W-1:0] data,
  output logic [LANES-1:0]        par
);

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    assign par[n] = even_fill(data[n*LANE_W +: LANE_W]);
  end

endmodule

// File: rtl/lane_par_cmp.sv
module lane_par_cmp
  import blpar_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic [LANES*LANE_W-1:0] data,
  input  logic [LANES-1:0]        par,
  input  logic [LANES-1:0]        be,
  output logic [LANES-1:0]        flag
);

  logic [LANES-1:0] raw_bad;

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    assign raw_bad[n] = lane_bad(data[n*LANE_W +: LANE_W], par[n]);
    assign flag[n]    = raw_bad[n] & be[n];
  end

endmodule

// File: rtl/byte_lane_parity_chk.sv
module byte_lane_parity_chk
  import blpar_pkg::*;
#(
  parameter int unsigned LANES = 8,
  localparam int unsigned DW   = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    rd_data,
  input  logic [LANES-1:0] rd_par,
  input  logic [LANES-1:0] rd_be,
  input  logic             par_chk_en,
  input  logic             rd_valid,
  input  logic [DW-1:0]    wr_data,
  output logic [LANES-1:0] wr_par,
  output logic             chk_n,
  output logic [LANES-1:0] lane_err
);

  // Named internal events
  logic [LANES-1:0] lane_flag;   // enabled lanes that mismatch
  logic             chk_gate;    // a check is reported this cycle
  logic [LANES-1:0] err_next;
  logic             hit_next;

  lane_par_gen #(.LANES(LANES)) u_gen (
    .data (wr_data),
    .par  (wr_par)
  );

  lane_par_cmp #(.LANES(LANES)) u_cmp (
    .data (rd_data),
    .par  (rd_par),
    .be   (rd_be),
    .flag (lane_flag)
  );

  assign chk_gate = rd_valid & par_chk_en;
  assign err_next = chk_gate ? lane_flag : '0;
  assign hit_next = |err_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_n    <= 1'b1;
      lane_err <= '0;
    end else begin
      chk_n    <= ~hit_next;
      lane_err <= err_next;
    end
  end

  // ---------------- assertions ----------------
  AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> chk_n && lane_err == '0); // R1
  AST_LANE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && par_chk_en |=> lane_err == $past(lane_flag)); // R2
  AST_MASKED_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lane_err & ~$past(rd_be)) == '0); // R3
  AST_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> chk_n && lane_err == '0); // R5
  AST_PEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !par_chk_en |=> chk_n); // R6
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chk_n) |-> $past(rd_valid) && $past(par_chk_en)); // R7
  AST_ERR_CONSIST: assert property (@(posedge clk) disable iff (!rst_n)
    chk_n == (lane_err == '0)); // R8
  AST_WR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({wr_data, wr_par}) % 2) == 0); // R9
  AST_NO_BE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_be == '0 |=> chk_n); // R10

endmodule

// File: tb/byte_lane_parity_chk_tb.sv
module byte_lane_parity_chk_tb;

  typedef struct {
    logic [8:0] v;     // {chk_n, lane_err}
    string      req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] rd_data = '0;
  logic [7:0]  rd_par = '0;
  logic [7:0]  rd_be = '0;
  logic        par_chk_en = 1'b0;
  logic        rd_valid = 1'b0;
  logic [63:0] wr_data = '0;
  logic [7:0]  wr_par;
  logic        chk_n;
  logic [7:0]  lane_err;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 0;
  exp_t sb[$];

  always #10 clk = ~clk;   // 50 MHz

  byte_lane_parity_chk u_dut (
    .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .rd_par(rd_par),
    .rd_be(rd_be), .par_chk_en(par_chk_en), .rd_valid(rd_valid),
    .wr_data(wr_data), .wr_par(wr_par), .chk_n(chk_n), .lane_err(lane_err)
  );

  // Bench's own parity: count ones bit by bit.
  function automatic bit odd_ones(input logic [7:0] b);
    int c = 0;
    for (int i = 0; i < 8; i++) c += b[i];
    return (c % 2) == 1;
  endfunction

  function automatic logic [7:0] good_par(input logic [63:0] d);
    logic [7:0] p;
    for (int l = 0; l < 8; l++) p[l] = odd_ones(d[l*8 +: 8]);
    return p;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: apply one cycle, then push the expected registered result.
  task automatic drive(input logic [63:0] d, input logic [7:0] p, input logic [7:0] be,
                       input logic en, input logic vld, input string req);
    exp_t e;
    logic [7:0] err;
    @(negedge clk);
    rd_data = d; rd_par = p; rd_be = be; par_chk_en = en; rd_valid = vld;
    for (int l = 0; l < 8; l++) begin
      bit mism;
      mism   = odd_ones(d[l*8 +: 8]) != p[l];
      err[l] = vld && en && be[l] && mism;
    end
    e.v   = {(err == 8'h00), err};
    e.req = req;
    @(posedge clk);
    #1 sb.push_back(e);
  endtask

  // Monitor: compare registered outputs on the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.req, {55'd0, chk_n, lane_err}, {55'd0, e.v});
      end
    end
  end

  task automatic wr_check(input logic [63:0] d);
    @(negedge clk);
    wr_data = d;
    #1 check("R9", {56'd0, wr_par}, {56'd0, good_par(d)});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    // R1: outputs idle during and right after reset
    check("R1", {55'd0, chk_n, lane_err}, {55'd0, 1'b1, 8'h00});
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {55'd0, chk_n, lane_err}, {55'd0, 1'b1, 8'h00});

    // R2: clean data, all lanes enabled
    d = 64'h0123_4567_89AB_CDEF;
    drive(d, good_par(d), 8'hFF, 1, 1, "R2");
    // R2 R8: each lane corrupted alone
    for (int l = 0; l < 8; l++) begin
      d = {$urandom, $urandom};
      drive(d, good_par(d) ^ (8'h01 << l), 8'hFF, 1, 1, "R2_R8");
    end
    // R3: bad lane 5 disabled, others good
    d = 64'hFFFF_0000_AAAA_5555;
    drive(d, good_par(d) ^ 8'h20, 8'hDF, 1, 1, "R3");
    // R4: gapped enables, lanes 0 and 1 bad, only lane 0 enabled
    drive(d, good_par(d) ^ 8'h03, 8'hA5, 1, 1, "R4");
    drive(d, good_par(d) ^ 8'hFF, 8'h5A, 1, 1, "R4");
    // R5: no strobe with bad data
    drive(d, ~good_par(d), 8'hFF, 1, 0, "R5");
    // R6: parity enable off
    drive(d, ~good_par(d), 8'hFF, 0, 1, "R6");
    // R10: no enables
    drive(d, ~good_par(d), 8'h00, 1, 1, "R10");
    // R7: back-to-back failing strobes then idle and clean
    drive(d, good_par(d) ^ 8'h80, 8'hFF, 1, 1, "R7");
    drive(d, good_par(d) ^ 8'h01, 8'hFF, 1, 1, "R7");
    drive(d, good_par(d) ^ 8'h01, 8'hFF, 1, 0, "R7");
    drive(d, good_par(d), 8'hFF, 1, 1, "R7");
    // Random mix
    for (int k = 0; k < 300; k++) begin
      d = {$urandom, $urandom};
      drive(d, good_par(d) ^ 8'($urandom & $urandom), 8'($urandom),
            ($urandom % 4) != 0, ($urandom % 3) != 0, "R8");
    end
    drive(d, good_par(d), 8'h00, 0, 0, "R5");
    repeat (2) @(negedge clk);
    // R9: write parity generator, independent of rd_be
    rd_be = 8'h00;
    wr_check(64'h0);
    wr_check(64'hFFFF_FFFF_FFFF_FFFF);
    rd_be = 8'h3C;
    wr_check(64'h0102_0408_1020_4080);
    for (int k = 0; k < 40; k++) wr_check({$urandom, $urandom});
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule